// File: doc/BRIEF.md
# Predicated Load-and-Broadcast Vector Unit

This unit executes one scalable-vector load form: a single 32-bit word is read from memory and copied into every active lane of a destination vector. Lanes that are not active are cleared. The caller hands over the 32-bit instruction word together with three operand values: the general register named by the base field, the stack pointer and the governing predicate. To let a register file supply those values, the unit also exposes the base and predicate register indices it decodes. The unit forms the effective address, runs one read over a valid/ready request port, waits for the response, and then pulses `done` with the destination index and the finished vector.

Each instruction picks 32-bit or 64-bit lanes. The predicate decides whether memory is touched at all. When no lane is active, the unit issues no read, so no data abort can occur, and it completes with an all-zero vector. When the stack pointer is the base, its alignment is checked first. An unaligned stack pointer raises a fault instead of reading. A read error aborts the operation and leaves the destination unwritten. The vector length is a parameter.

Top module: `vec_bcast_load`

## Requirements
- R1: A request is recognised only when instr[31:25]=1000010, instr[24:23]=10, instr[22]=1, instr[15]=1 and instr[14]=1. Any other word gives a one-cycle `badOp` pulse in the cycle after acceptance, with no memory request and no `done`.
- R2: When instr[9:5] is not 31, the read address is `gprBase` plus instr[21:16] times 4. This is a byte offset from 0 to 252.
- R3: When instr[9:5] is 31, the base is `stackPtr` and `memTagCheck` is 0 on the request. For any other base register, `memTagCheck` is 1.
- R4: When instr[9:5] is 31 and stackPtr[3:0] is not zero, `alignFault` pulses in the cycle after acceptance. No read is issued and no `done` follows.
- R5: With instr[13]=0 the vector holds 32-bit lanes. Lane e is active when predMask[4e] is 1, and its other three predicate bits are ignored. An active lane holds the read word and an inactive lane holds zero.
- R6: With instr[13]=1 the vector holds 64-bit lanes. Lane e is active when predMask[8e] is 1, and the other seven bits are ignored. An active lane holds the read word zero-extended to 64 bits.
- R7: When no lane is active, no read is issued and `done` pulses in the cycle after acceptance with an all-zero vector. If the stack pointer is the base and is unaligned, `alignFault` is raised instead (parameter CHECK_SP_IDLE=1, the default).
- R8: `memReqValid` stays high with a stable `memAddr` until `memReqReady`. `done` pulses in the cycle after an error-free `memRspValid`.
- R9: A response with `memRspErr` set gives a one-cycle `memAbort` pulse in the following cycle and no `done`.
- R10: During the `done` pulse, `doneZt` equals instr[4:0] of the request.
- R11: `reqReady` is 1 after reset and whenever the unit is idle. It is 0 from acceptance until the completing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Unit idle, request accepted this cycle |
| instr | input | 32 | Instruction word |
| gprBase | input | 64 | Value of the general register named by instr[9:5] |
| stackPtr | input | 64 | Stack pointer value |
| predMask | input | VLEN/8 | Governing predicate, one bit per vector byte |
| baseSel | output | 5 | Base register index decoded from `instr` |
| predSel | output | 3 | Predicate register index decoded from `instr` |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Read request accepted |
| memAddr | output | 64 | Byte address of the 32-bit read |
| memTagCheck | output | 1 | Tag check requested for this read |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response word |
| memRspErr | input | 1 | Read response error |
| done | output | 1 | One-cycle completion pulse |
| doneZt | output | 5 | Destination register index, valid with `done` |
| doneVec | output | VLEN | Result vector, valid with `done` |
| alignFault | output | 1 | One-cycle stack-pointer alignment fault pulse |
| badOp | output | 1 | One-cycle unrecognised-encoding pulse |
| memAbort | output | 1 | One-cycle read-error abort pulse |

## Verification
Three results are due one cycle after acceptance: `badOp`, `alignFault` and the `done` that follows a request with no active lane. For a request that reads memory, `done` or `memAbort` is due one cycle after the response is driven. The bench drives every input on the falling edge and counts falling edges from acceptance and from the response, so it can require each pulse at exactly that count. The same sampling points confirm that no read was requested when none is allowed, that the address held still while `memReqReady` was withheld, and that `reqReady` stayed low between acceptance and completion.

// File: rtl/bcast_load_pkg.sv
package bcast_load_pkg;

  typedef struct packed {
    logic capture;
    logic loadWord;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } ctlState_t;

  localparam logic [6:0] OPC_HI = 7'b1000010;
  localparam logic [1:0] OPC_TY = 2'b10;
  localparam logic [4:0] SP_IDX = 5'd31;

endpackage

// File: rtl/bcast_load_dp.sv
module bcast_load_dp
  import bcast_load_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [31:0]         instr,
  input  logic [63:0]         gprBase,
  input  logic [63:0]         stackPtr,
  input  logic [VLEN/8-1:0]   predMask,
  input  logic [31:0]         memRspData,
  output logic                opMatch,
  output logic                useSp,
  output logic                spMisaligned,
  output logic                anyActiveIn,
  output logic                capAnyActive,
  output logic [63:0]         memAddr,
  output logic                memTagCheck,
  output logic [4:0]          curZt,
  output logic [VLEN-1:0]     resultVec
);

  localparam int LANES32 = VLEN / 32;
  localparam int LANES64 = VLEN / 64;

  logic [LANES32-1:0] act32In, act32Reg;
  logic [LANES64-1:0] act64In, act64Reg;
  logic [63:0]        addrNext;
  logic               e64In, e64Reg;
  logic [31:0]        wordReg;
  logic [VLEN-1:0]    vec32, vec64;
  logic               unusedPredBits;

  assign unusedPredBits = ^predMask;

  assign opMatch = (instr[31:25] == OPC_HI) && (instr[24:23] == OPC_TY) &&
                   instr[22] && instr[15] && instr[14];
  assign e64In        = instr[13];
  assign useSp        = (instr[9:5] == SP_IDX);
  assign spMisaligned = |stackPtr[3:0];
  assign addrNext     = (useSp ? stackPtr : gprBase) + {56'd0, instr[21:16], 2'b00};

  for (genvar i = 0; i < LANES32; i++) begin : g_act32
    assign act32In[i] = predMask[i*4];
    assign vec32[i*32 +: 32] = act32Reg[i] ? wordReg : 32'd0;
  end

  for (genvar j = 0; j < LANES64; j++) begin : g_act64
    assign act64In[j] = predMask[j*8];
    assign vec64[j*64 +: 64] = act64Reg[j] ? {32'd0, wordReg} : 64'd0;
  end

  assign anyActiveIn = e64In ? |act64In : |act32In;
  assign resultVec   = e64Reg ? vec64 : vec32;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr      <= '0;
      memTagCheck  <= 1'b0;
      curZt        <= '0;
      e64Reg       <= 1'b0;
      act32Reg     <= '0;
      act64Reg     <= '0;
      capAnyActive <= 1'b0;
      wordReg      <= '0;
    end else begin
      if (strobes.capture) begin
        memAddr      <= addrNext;
        memTagCheck  <= !useSp;
        curZt        <= instr[4:0];
        e64Reg       <= e64In;
        act32Reg     <= act32In;
        act64Reg     <= act64In;
        capAnyActive <= anyActiveIn;
      end
      if (strobes.loadWord) begin
        wordReg <= memRspData;
      end
    end
  end

endmodule

// File: rtl/bcast_load_ctl.sv
module bcast_load_ctl
  import bcast_load_pkg::*;
#(
  parameter bit CHECK_SP_IDLE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        opMatch,
  input  logic        useSp,
  input  logic        spMisaligned,
  input  logic        anyActiveIn,
  input  logic        capAnyActive,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        memRspErr,
  output ctlStrobes_t strobes,
  output logic        done,
  output logic        alignFault,
  output logic        badOp,
  output logic        memAbort
);

  ctlState_t state;
  logic      idleSpCheck;
  logic      faultNow;
  logic      accept;

  if (CHECK_SP_IDLE) begin : g_idle_chk
    assign idleSpCheck = 1'b1;
  end else begin : g_idle_skip
    assign idleSpCheck = 1'b0;
  end

  assign reqReady    = (state == ST_IDLE);
  assign accept      = reqReady && reqValid;
  assign memReqValid = (state == ST_ISSUE);
  assign faultNow    = useSp && spMisaligned && (anyActiveIn || idleSpCheck);

  assign strobes.capture  = accept && opMatch;
  assign strobes.loadWord = (state == ST_WAIT) && memRspValid && !memRspErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      alignFault <= 1'b0;
      badOp      <= 1'b0;
      memAbort   <= 1'b0;
    end else begin
      done       <= 1'b0;
      alignFault <= 1'b0;
      badOp      <= 1'b0;
      memAbort   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!opMatch)          badOp      <= 1'b1;
            else if (faultNow)     alignFault <= 1'b1;
            else if (!anyActiveIn) done       <= 1'b1;
            else                   state      <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (memReqReady) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (memRspValid) begin
            if (memRspErr) memAbort <= 1'b1;
            else           done     <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  read_needs_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> capAnyActive);

  // R4
  fault_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (!memReqValid && $past(reqValid)));

  // R9
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, alignFault, badOp, memAbort}));

  // R8
  done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(memRspValid && !memRspErr) || !capAnyActive));

endmodule

// File: rtl/vec_bcast_load.sv
module vec_bcast_load
  import bcast_load_pkg::*;
#(
  parameter int VLEN          = 256,
  parameter bit CHECK_SP_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       instr,
  input  logic [63:0]       gprBase,
  input  logic [63:0]       stackPtr,
  input  logic [VLEN/8-1:0] predMask,
  output logic [4:0]        baseSel,
  output logic [2:0]        predSel,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [63:0]       memAddr,
  output logic              memTagCheck,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  input  logic              memRspErr,
  output logic              done,
  output logic [4:0]        doneZt,
  output logic [VLEN-1:0]   doneVec,
  output logic              alignFault,
  output logic              badOp,
  output logic              memAbort
);

  ctlStrobes_t     strobes;
  logic            opMatch, useSp, spMisaligned, anyActiveIn, capAnyActive;
  logic [4:0]      curZt;
  logic [VLEN-1:0] resultVec;

  assign baseSel = instr[9:5];
  assign predSel = instr[12:10];

  bcast_load_dp #(.VLEN(VLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instr(instr),
    .gprBase(gprBase), .stackPtr(stackPtr), .predMask(predMask),
    .memRspData(memRspData), .opMatch(opMatch), .useSp(useSp),
    .spMisaligned(spMisaligned), .anyActiveIn(anyActiveIn),
    .capAnyActive(capAnyActive), .memAddr(memAddr),
    .memTagCheck(memTagCheck), .curZt(curZt), .resultVec(resultVec)
  );

  bcast_load_ctl #(.CHECK_SP_IDLE(CHECK_SP_IDLE)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .opMatch(opMatch), .useSp(useSp), .spMisaligned(spMisaligned),
    .anyActiveIn(anyActiveIn), .capAnyActive(capAnyActive),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspErr(memRspErr), .strobes(strobes),
    .done(done), .alignFault(alignFault), .badOp(badOp), .memAbort(memAbort)
  );

  assign doneZt  = done ? curZt : 5'd0;
  assign doneVec = done ? resultVec : '0;

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memAddr)));

endmodule

// File: tb/vec_bcast_load_tb.sv
module vec_bcast_load_tb;

  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic [31:0]     instr = '0;
  logic [63:0]     gprBase = '0;
  logic [63:0]     stackPtr = '0;
  logic [PW-1:0]   predMask = '0;
  logic [4:0]      baseSel;
  logic [2:0]      predSel;
  logic            memReqValid;
  logic            memReqReady = 1'b0;
  logic [63:0]     memAddr;
  logic            memTagCheck;
  logic            memRspValid = 1'b0;
  logic [31:0]     memRspData = '0;
  logic            memRspErr = 1'b0;
  logic            done;
  logic [4:0]      doneZt;
  logic [VLEN-1:0] doneVec;
  logic            alignFault, badOp, memAbort;

  int checks = 0;
  int errors = 0;

  bit sawMem, addrMoved, tagSeen, readyLeak, idleReady;
  bit gotDone, gotAlign, gotBad, gotAbort;
  logic [63:0]     addrSeen;
  logic [VLEN-1:0] vecSeen;
  logic [4:0]      ztSeen;
  int eventAt, rspAt;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_bcast_load #(.VLEN(VLEN)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .instr(instr), .gprBase(gprBase), .stackPtr(stackPtr), .predMask(predMask),
    .baseSel(baseSel), .predSel(predSel),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memAddr(memAddr),
    .memTagCheck(memTagCheck), .memRspValid(memRspValid), .memRspData(memRspData),
    .memRspErr(memRspErr), .done(done), .doneZt(doneZt), .doneVec(doneVec),
    .alignFault(alignFault), .badOp(badOp), .memAbort(memAbort)
  );

  function automatic logic [31:0] mk(input logic [5:0] imm, input bit e64,
                                     input logic [4:0] rn, input logic [4:0] zt);
    return {7'b1000010, 2'b10, 1'b1, imm, 1'b1, 1'b1, e64, 3'd2, rn, zt};
  endfunction

  function automatic logic [VLEN-1:0] expVec(input bit e64, input logic [PW-1:0] pr,
                                             input logic [31:0] w);
    logic [VLEN-1:0] v = '0;
    if (!e64) begin
      for (int e = 0; e < VLEN/32; e++) if (pr[e*4]) v[e*32 +: 32] = w;
    end else begin
      for (int e = 0; e < VLEN/64; e++) if (pr[e*8]) v[e*64 +: 64] = {32'd0, w};
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [31:0] ins, input logic [63:0] gpr,
                       input logic [63:0] sp, input logic [PW-1:0] pr,
                       input int rdyDly, input logic [31:0] word, input bit err);
    int waitCnt = 0;
    int phase = 0;
    sawMem = 0; addrMoved = 0; tagSeen = 0; readyLeak = 0;
    gotDone = 0; gotAlign = 0; gotBad = 0; gotAbort = 0;
    addrSeen = '0; vecSeen = '0; ztSeen = '0; eventAt = -1; rspAt = -1;
    @(negedge clk);
    idleReady = reqReady;
    reqValid = 1'b1; instr = ins; gprBase = gpr; stackPtr = sp; predMask = pr;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      reqValid = 1'b0;
      memReqReady = 1'b0; memRspValid = 1'b0; memRspErr = 1'b0;
      if (done || alignFault || badOp || memAbort) begin
        gotDone = done; gotAlign = alignFault; gotBad = badOp; gotAbort = memAbort;
        vecSeen = doneVec; ztSeen = doneZt; eventAt = c;
        break;
      end
      if (reqReady) readyLeak = 1;
      if (memReqValid) begin
        if (!sawMem) addrSeen = memAddr;
        else if (memAddr != addrSeen) addrMoved = 1;
        sawMem = 1;
        tagSeen = memTagCheck;
        if (waitCnt >= rdyDly) begin
          memReqReady = 1'b1;
          phase = 1;
        end else waitCnt++;
      end else if (phase == 1) begin
        memRspValid = 1'b1; memRspData = word; memRspErr = err;
        rspAt = c; phase = 2;
      end
    end
  endtask

  task automatic t_reset;
    chk(reqReady == 1'b1, "R11", "reqReady after reset", reqReady, 1);
    chk(memReqValid == 1'b0, "R8", "memReqValid after reset", memReqValid, 0);
    chk(done == 1'b0, "R10", "done after reset", done, 0);
  endtask

  task automatic t_basic32;
    logic [63:0] b = 64'h1000_0000_0000_0040;
    runOp(mk(6'd5, 0, 5'd4, 5'd7), b, 64'h0, '1, 0, 32'hDEAD_BEEF, 0);
    chk(idleReady, "R11", "ready before request", idleReady, 1);
    chk(sawMem && addrSeen == b + 64'd20, "R2", "address base+20", addrSeen, b + 64'd20);
    chk(tagSeen == 1'b1, "R3", "tag check for general base", tagSeen, 1);
    chk(gotDone && eventAt == rspAt + 1, "R8", "done one cycle after response", eventAt, rspAt + 1);
    chk(vecSeen == expVec(0, '1, 32'hDEAD_BEEF), "R5", "all lanes 32", vecSeen, expVec(0, '1, 32'hDEAD_BEEF));
    chk(ztSeen == 5'd7, "R10", "destination index", ztSeen, 7);
    chk(!readyLeak, "R11", "ready low while busy", readyLeak, 0);
  endtask

  task automatic t_partial32;
    logic [PW-1:0] p = 32'h8421_0F01;
    runOp(mk(6'd63, 0, 5'd1, 5'd3), 64'h2000, 64'h0, p, 3, 32'h1234_5678, 0);
    chk(addrSeen == 64'h2000 + 64'd252, "R2", "max offset 252", addrSeen, 64'h2000 + 64'd252);
    chk(!addrMoved && sawMem, "R8", "address stable while not ready", addrMoved, 0);
    chk(gotDone && vecSeen == expVec(0, p, 32'h1234_5678), "R5", "lowest byte bit governs 32 lane", vecSeen, expVec(0, p, 32'h1234_5678));
  endtask

  task automatic t_lanes64;
    logic [PW-1:0] p = 32'h0000_01FE;
    runOp(mk(6'd0, 1, 5'd2, 5'd9), 64'h3000, 64'h0, p, 1, 32'hFFFF_FFFF, 0);
    chk(addrSeen == 64'h3000, "R2", "zero offset", addrSeen, 64'h3000);
    chk(gotDone && vecSeen == expVec(1, p, 32'hFFFF_FFFF), "R6", "zero-extended 64 lanes", vecSeen, expVec(1, p, 32'hFFFF_FFFF));
    chk(ztSeen == 5'd9, "R10", "destination index 64", ztSeen, 9);
  endtask

  task automatic t_spBase;
    runOp(mk(6'd1, 0, 5'd31, 5'd0), 64'hFFFF_0000_0000_0000, 64'h7FF0, '1, 0, 32'hA5A5_0001, 0);
    chk(sawMem && addrSeen == 64'h7FF4, "R3", "stack pointer base", addrSeen, 64'h7FF4);
    chk(tagSeen == 1'b0, "R3", "no tag check on stack base", tagSeen, 0);
    chk(gotDone, "R8", "stack base completes", gotDone, 1);
  endtask

  task automatic t_spFault;
    runOp(mk(6'd2, 0, 5'd31, 5'd5), 64'h0, 64'h7FF8, '1, 0, 32'h0, 0);
    chk(gotAlign && eventAt == 0, "R4", "fault one cycle after accept", eventAt, 0);
    chk(!sawMem && !gotDone, "R4", "no read and no done on fault", {sawMem, gotDone}, 0);
  endtask

  task automatic t_noActive;
    runOp(mk(6'd4, 0, 5'd3, 5'd12), 64'h4000, 64'h0, 32'hEEEE_EEEE, 0, 32'hFFFF_FFFF, 0);
    chk(gotDone && eventAt == 0, "R7", "idle predicate done next cycle", eventAt, 0);
    chk(!sawMem, "R7", "no read with no lane", sawMem, 0);
    chk(vecSeen == '0 && ztSeen == 5'd12, "R7", "zero vector", vecSeen, 0);
    runOp(mk(6'd4, 1, 5'd3, 5'd13), 64'h4000, 64'h0, 32'h1010_1010, 0, 32'hFFFF_FFFF, 0);
    chk(gotDone && !sawMem && vecSeen == '0, "R6", "64 lanes ignore nibble bits", vecSeen, 0);
    runOp(mk(6'd4, 0, 5'd31, 5'd14), 64'h0, 64'h7FF2, '0, 0, 32'h0, 0);
    chk(gotAlign && !gotDone && !sawMem, "R7", "idle predicate still checks stack", gotAlign, 1);
  endtask

  task automatic t_badEnc;
    runOp(mk(6'd4, 0, 5'd3, 5'd1) & ~32'h0040_0000, 64'h0, 64'h0, '1, 0, 32'h0, 0);
    chk(gotBad && eventAt == 0 && !sawMem && !gotDone, "R1", "bit 22 clear rejected", eventAt, 0);
    runOp(mk(6'd4, 0, 5'd3, 5'd1) & ~32'h0000_4000, 64'h0, 64'h0, '1, 0, 32'h0, 0);
    chk(gotBad && !sawMem && !gotDone, "R1", "bit 14 clear rejected", gotBad, 1);
    chk(baseSel == 5'd3 && predSel == 3'd2, "R1", "register indices", {predSel, baseSel}, {3'd2, 5'd3});
  endtask

  task automatic t_memErr;
    runOp(mk(6'd8, 0, 5'd6, 5'd20), 64'h5000, 64'h0, '1, 2, 32'h5555_5555, 1);
    chk(gotAbort && eventAt == rspAt + 1, "R9", "abort one cycle after error", eventAt, rspAt + 1);
    chk(!gotDone, "R9", "no done after error", gotDone, 0);
    runOp(mk(6'd3, 0, 5'd6, 5'd31), 64'h5000, 64'h0, 32'h0000_0001, 0, 32'h0BAD_F00D, 0);
    chk(gotDone && ztSeen == 5'd31 && vecSeen == expVec(0, 32'h1, 32'h0BAD_F00D), "R10", "recovery after abort", vecSeen, expVec(0, 32'h1, 32'h0BAD_F00D));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic32();
    t_partial32();
    t_lanes64();
    t_spBase();
    t_spFault();
    t_noActive();
    t_badEnc();
    t_memErr();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule